// File: doc/BRIEF.md
# Multi-Channel ADC Scan Sequencer

This block drives an external analog-to-digital converter across a contiguous range of input channels and collects the conversion results in an on-chip sample queue. One register write sets the range. That same write puts the channel pointer back to the bottom of the range. Every conversion request then converts the channel under the pointer. When the result comes back, the pointer moves up by one. After the top channel it wraps back to the bottom.

The converter is modelled as a start pulse carrying a channel number, followed later by a done pulse carrying a 16-bit two's-complement result. Results leave the block on a valid/ready stream. A result stays presented, unchanged, for as long as the consumer holds ready low. Back-pressure does not stall conversions; it only lets the queue fill. Once the queue is full, further results are discarded and a sticky overflow flag is raised.

A busy flag covers a whole pass over the range. A settling flag runs for a fixed time after any range or gain write, and conversion requests are held back until that time has passed. An interrupt flag rises when the queue level reaches a programmed threshold. Software is expected to set this threshold to a whole number of scan lengths.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, adc_start, scan_busy, settle_wait, smp_valid, thr_irq and fifo_ovf are 0, and cur_chan and fifo_level are 0.
- R2: A range write takes the top channel from rng_wdata[7:4] and the bottom channel from rng_wdata[3:0]. On the cycle after the write, cur_chan equals the bottom channel.
- R3: Each conversion uses adc_chan equal to cur_chan. Each done pulse advances cur_chan by one, and the done pulse for the top channel returns it to the bottom channel. For example, a write of 0x20 followed by four conversions uses channels 0, 1, 2, 0.
- R4: scan_busy rises on the cycle after a conversion starts. It stays high between the conversions of one pass, and it is low on the cycle after the done pulse of the top channel's conversion.
- R5: A range write or a gain write holds settle_wait high for exactly SETTLE_CYC = CLK_MHZ*SETTLE_US cycles, beginning on the cycle after the write (1250 cycles with the defaults).
- R6: adc_start is never high while settle_wait is high. A request made during the settling time starts its conversion on the first cycle in which settle_wait is low.
- R7: Results come out in conversion order. smp_valid is high whenever fifo_level is non-zero. While smp_valid is high and smp_ready is low, smp_data holds steady. A transfer takes place on a cycle with both high, and fifo_level counts the stored samples.
- R8: The queue holds DEPTH (48) samples. A done pulse that arrives while the queue is full is discarded: fifo_level stays at DEPTH and fifo_ovf becomes 1. fifo_ovf stays at 1 until irq_clr.
- R9: thr_irq becomes 1 on the cycle after fifo_level is at or above the threshold set by thr_we/thr_wdata (reset value DEPTH). It stays 1 until an irq_clr pulse clears it. After the clear it sets again only if the level is still at or above the threshold.
- R10: A request made while a conversion is in flight is held. Its adc_start comes on the cycle after the done pulse of the earlier conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rng_we | input | 1 | Channel range write strobe |
| rng_wdata | input | 8 | Range: top channel [7:4], bottom channel [3:0] |
| gain_we | input | 1 | Gain write strobe (starts settling time only) |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | 6 | Interrupt threshold in samples |
| conv_req | input | 1 | Conversion request pulse |
| adc_start | output | 1 | Converter start pulse |
| adc_chan | output | 4 | Channel for the conversion being started |
| adc_done | input | 1 | Converter result pulse |
| adc_data | input | 16 | Converter result, two's complement |
| smp_valid | output | 1 | Sample stream valid |
| smp_ready | input | 1 | Sample stream ready |
| smp_data | output | 16 | Sample stream data |
| fifo_level | output | 6 | Number of stored samples |
| scan_busy | output | 1 | A pass over the range is in progress |
| settle_wait | output | 1 | Analog settling time running |
| cur_chan | output | 4 | Channel the next conversion will use |
| thr_irq | output | 1 | Queue threshold interrupt flag |
| irq_clr | input | 1 | Clears thr_irq and fifo_ovf |
| fifo_ovf | output | 1 | Sticky sample-drop flag |

## Verification
A request sampled at one edge produces adc_start in the cycle after that edge, because adc_start is combinational from the pending bit. A done pulse sampled at an edge updates cur_chan, scan_busy and fifo_level at that same edge, so the bench checks those values at the next falling edge. thr_irq trails the level by one more register, so its check comes one falling edge later. settle_wait is counted falling edge by falling edge from the edge after the write, and the bench also checks that adc_start stays low on each of those edges and rises on the first edge after the count ends.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CH_W = 4;

  typedef logic [CH_W-1:0] chan_t;

  typedef struct packed {
    chan_t hi;
    chan_t lo;
  } chan_rng_t;

  // next channel in a scan: wrap from top back to bottom
  function automatic chan_t chan_step(chan_t c, chan_rng_t r);
    return (c == r.hi) ? r.lo : chan_t'(c + 1'b1);
  endfunction
endpackage

// File: rtl/adc_settle_timer.sv
module adc_settle_timer #(
  parameter int CYC = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic waiting
);
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (kick)        cnt <= CW'(CYC);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign waiting = (cnt != '0);
endmodule

// File: rtl/adc_chan_seq.sv
module adc_chan_seq
  import adc_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rng_we,
  input  chan_rng_t rng_wdata,
  input  logic      conv_req,
  input  logic      hold,
  input  logic      adc_done,
  output logic      adc_start,
  output chan_t     cur_chan,
  output logic      scan_busy
);
  chan_rng_t rng;
  logic      pend;
  logic      inflight;
  logic      launch;

  assign launch    = pend & ~hold & ~inflight;
  assign adc_start = launch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rng       <= '0;
      cur_chan  <= '0;
      pend      <= 1'b0;
      inflight  <= 1'b0;
      scan_busy <= 1'b0;
    end else begin
      if (launch)   pend <= 1'b0;
      if (conv_req) pend <= 1'b1;
      if (launch) begin
        inflight  <= 1'b1;
        scan_busy <= 1'b1;
      end
      if (adc_done) begin
        inflight <= 1'b0;
        cur_chan <= chan_step(cur_chan, rng);
        if (cur_chan == rng.hi) scan_busy <= 1'b0;
      end
      if (rng_we) begin
        rng       <= rng_wdata;
        cur_chan  <= rng_wdata.lo;
        scan_busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adc_sample_fifo.sv
module adc_sample_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 48
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       ovf_clr,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [W-1:0]               out_data,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       ovf
);
  localparam int PW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          do_push, do_pop, drop;

  assign out_valid = (level != '0);
  assign out_data  = mem[rp];
  assign do_pop    = out_valid & out_ready;
  assign drop      = push & (level == LW'(DEPTH));
  assign do_push   = push & ~drop;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
      ovf   <= 1'b0;
    end else begin
      if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      level <= level + LW'(do_push) - LW'(do_pop);
      if (drop)         ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int DEPTH     = 48,
  parameter int CLK_MHZ   = 125,
  parameter int SETTLE_US = 10,
  localparam int LVL_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rng_we,
  input  logic [7:0]        rng_wdata,
  input  logic              gain_we,
  input  logic              thr_we,
  input  logic [LVL_W-1:0]  thr_wdata,
  input  logic              conv_req,
  output logic              adc_start,
  output logic [CH_W-1:0]   adc_chan,
  input  logic              adc_done,
  input  logic [DATA_W-1:0] adc_data,
  output logic              smp_valid,
  input  logic              smp_ready,
  output logic [DATA_W-1:0] smp_data,
  output logic [LVL_W-1:0]  fifo_level,
  output logic              scan_busy,
  output logic              settle_wait,
  output logic [CH_W-1:0]   cur_chan,
  output logic              thr_irq,
  input  logic              irq_clr,
  output logic              fifo_ovf
);
  localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;

  logic [LVL_W-1:0] thr;

  adc_settle_timer #(.CYC(SETTLE_CYC)) u_settle (
    .clk     (clk),
    .rst_n   (rst_n),
    .kick    (rng_we | gain_we),
    .waiting (settle_wait)
  );

  adc_chan_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .rng_we    (rng_we),
    .rng_wdata (chan_rng_t'(rng_wdata)),
    .conv_req  (conv_req),
    .hold      (settle_wait),
    .adc_done  (adc_done),
    .adc_start (adc_start),
    .cur_chan  (cur_chan),
    .scan_busy (scan_busy)
  );

  assign adc_chan = cur_chan;

  adc_sample_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (adc_done),
    .push_data (adc_data),
    .ovf_clr   (irq_clr),
    .out_valid (smp_valid),
    .out_ready (smp_ready),
    .out_data  (smp_data),
    .level     (fifo_level),
    .ovf       (fifo_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr     <= LVL_W'(DEPTH);
      thr_irq <= 1'b0;
    end else begin
      if (thr_we) thr <= thr_wdata;
      if (irq_clr)                 thr_irq <= 1'b0;
      else if (fifo_level >= thr)  thr_irq <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int DEPTH = 48,
  parameter int LVL_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rng_we,
  input logic [7:0]       rng_wdata,
  input logic             adc_start,
  input logic             adc_done,
  input logic [3:0]       cur_chan,
  input logic             scan_busy,
  input logic             settle_wait,
  input logic             smp_valid,
  input logic             smp_ready,
  input logic [15:0]      smp_data,
  input logic [LVL_W-1:0] fifo_level,
  input logic             fifo_ovf,
  input logic             thr_irq,
  input logic             irq_clr
);
  // R2
  range_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rng_we |=> cur_chan == $past(rng_wdata[3:0]));
  // R4
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> scan_busy);
  // R5
  settle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rng_we |=> settle_wait);
  // R6
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    settle_wait |-> !adc_start);
  // R7
  stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready) |=> (smp_valid && $stable(smp_data)));
  // R8
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LVL_W'(DEPTH));
  // R8
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level == LVL_W'(DEPTH) && adc_done) |=> fifo_ovf);
  // R9
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |=> !thr_irq);
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rng_we      (rng_we),
  .rng_wdata   (rng_wdata),
  .adc_start   (adc_start),
  .adc_done    (adc_done),
  .cur_chan    (cur_chan),
  .scan_busy   (scan_busy),
  .settle_wait (settle_wait),
  .smp_valid   (smp_valid),
  .smp_ready   (smp_ready),
  .smp_data    (smp_data),
  .fifo_level  (fifo_level),
  .fifo_ovf    (fifo_ovf),
  .thr_irq     (thr_irq),
  .irq_clr     (irq_clr)
);

// File: tb/adc_scan_seq_bench.sv
module adc_scan_seq_bench;
  localparam int SETTLE = 1250;
  localparam int DEPTH  = 48;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rng_we = 1'b0;
  logic [7:0]  rng_wdata = '0;
  logic        gain_we = 1'b0;
  logic        thr_we = 1'b0;
  logic [5:0]  thr_wdata = '0;
  logic        conv_req = 1'b0;
  logic        adc_start;
  logic [3:0]  adc_chan;
  logic        adc_done;
  logic [15:0] adc_data;
  logic        smp_valid;
  logic        smp_ready = 1'b0;
  logic [15:0] smp_data;
  logic [5:0]  fifo_level;
  logic        scan_busy;
  logic        settle_wait;
  logic [3:0]  cur_chan;
  logic        thr_irq;
  logic        irq_clr = 1'b0;
  logic        fifo_ovf;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  adc_scan_seq u_adc_scan_seq (
    .clk(clk), .rst_n(rst_n), .rng_we(rng_we), .rng_wdata(rng_wdata),
    .gain_we(gain_we), .thr_we(thr_we), .thr_wdata(thr_wdata),
    .conv_req(conv_req), .adc_start(adc_start), .adc_chan(adc_chan),
    .adc_done(adc_done), .adc_data(adc_data), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_data(smp_data), .fifo_level(fifo_level),
    .scan_busy(scan_busy), .settle_wait(settle_wait), .cur_chan(cur_chan),
    .thr_irq(thr_irq), .irq_clr(irq_clr), .fifo_ovf(fifo_ovf)
  );

  // converter model: result 3 cycles after start, data = {chan, sequence}
  logic [1:0]  lat;
  logic [15:0] held;
  logic [11:0] seq;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat <= '0; held <= '0; seq <= '0; adc_done <= 1'b0; adc_data <= '0;
    end else begin
      adc_done <= 1'b0;
      if (adc_start) begin
        lat  <= 2'd3;
        held <= {adc_chan, seq};
        seq  <= seq + 1'b1;
      end else if (lat != 0) begin
        lat <= lat - 1'b1;
        if (lat == 2'd1) begin
          adc_done <= 1'b1;
          adc_data <= held;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_done();
    while (!adc_done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_settle();
    while (settle_wait) @(negedge clk);
  endtask

  task automatic write_range(input logic [7:0] v);
    rng_wdata = v; rng_we = 1'b1;
    @(negedge clk);
    rng_we = 1'b0;
  endtask

  task automatic do_conv(input logic [3:0] exp_ch);
    conv_req = 1'b1;
    @(negedge clk);
    conv_req = 1'b0;
    chk("R3 start", adc_start, 1);
    chk("R3 chan", adc_chan, exp_ch);
    wait_done();
  endtask

  task automatic pop(output logic [15:0] d);
    chk("R7 valid", smp_valid, 1);
    d = smp_data;
    smp_ready = 1'b1;
    @(negedge clk);
    smp_ready = 1'b0;
  endtask

  task automatic pulse_clr();
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 start", adc_start, 0);
    chk("R1 busy", scan_busy, 0);
    chk("R1 wait", settle_wait, 0);
    chk("R1 valid", smp_valid, 0);
    chk("R1 irq", thr_irq, 0);
    chk("R1 ovf", fifo_ovf, 0);
    chk("R1 chan", cur_chan, 0);
    chk("R1 level", fifo_level, 0);
  endtask

  task automatic t_settle_hold();
    int n = 0;
    logic [15:0] d;
    gain_we = 1'b1; conv_req = 1'b1;
    @(negedge clk);
    gain_we = 1'b0; conv_req = 1'b0;
    while (settle_wait) begin
      n++;
      if (adc_start) chk("R6 held", adc_start, 0);
      @(negedge clk);
    end
    chk("R5 length", n, SETTLE);
    chk("R6 release", adc_start, 1);
    wait_done();
    pop(d);
    chk("R7 data", d, 16'h0000);
  endtask

  task automatic t_scan_order();
    logic [11:0] s0;
    logic [15:0] d;
    write_range(8'h20);
    chk("R2 low", cur_chan, 0);
    chk("R5 gain-free write", settle_wait, 1);
    wait_settle();
    s0 = seq;
    do_conv(4'd0);
    chk("R4 mid", scan_busy, 1);
    chk("R3 adv", cur_chan, 1);
    do_conv(4'd1);
    chk("R4 mid2", scan_busy, 1);
    do_conv(4'd2);
    chk("R4 end", scan_busy, 0);
    chk("R3 wrap", cur_chan, 0);
    do_conv(4'd0);
    chk("R7 level", fifo_level, 4);
    d = smp_data;
    repeat (3) @(negedge clk);
    chk("R7 stall", smp_data, d);
    pop(d); chk("R7 d0", d, {4'd0, s0});
    pop(d); chk("R7 d1", d, {4'd1, 12'(s0 + 1)});
    pop(d); chk("R7 d2", d, {4'd2, 12'(s0 + 2)});
    pop(d); chk("R7 d3", d, {4'd0, 12'(s0 + 3)});
    chk("R7 empty", smp_valid, 0);
    // second range: bottom 5, top 6
    write_range(8'h65);
    chk("R2 low5", cur_chan, 5);
    wait_settle();
    do_conv(4'd5);
    do_conv(4'd6);
    chk("R3 wrap5", cur_chan, 5);
    pop(d); pop(d);
  endtask

  task automatic t_req_inflight();
    logic [15:0] d;
    conv_req = 1'b1;
    @(negedge clk);
    chk("R10 first", adc_start, 1);
    @(negedge clk);
    conv_req = 1'b0;
    chk("R10 held", adc_start, 0);
    while (!adc_done) begin
      if (adc_start) chk("R10 held", adc_start, 0);
      @(negedge clk);
    end
    @(negedge clk);
    chk("R10 launch", adc_start, 1);
    wait_done();
    pop(d); pop(d);
  endtask

  task automatic t_irq();
    logic [15:0] d;
    thr_wdata = 6'd3; thr_we = 1'b1;
    @(negedge clk);
    thr_we = 1'b0;
    do_conv(cur_chan);
    do_conv(cur_chan);
    chk("R9 below", thr_irq, 0);
    do_conv(cur_chan);
    chk("R9 lag", thr_irq, 0);
    @(negedge clk);
    chk("R9 set", thr_irq, 1);
    pulse_clr();
    chk("R9 cleared", thr_irq, 0);
    @(negedge clk);
    chk("R9 reassert", thr_irq, 1);
    pop(d); pop(d); pop(d);
    pulse_clr();
    repeat (2) @(negedge clk);
    chk("R9 stays clear", thr_irq, 0);
  endtask

  task automatic t_overflow();
    logic [11:0] s0;
    logic [15:0] d;
    int n = 0;
    thr_wdata = 6'd48; thr_we = 1'b1;
    @(negedge clk);
    thr_we = 1'b0;
    s0 = seq;
    for (int i = 0; i < DEPTH + 1; i++) do_conv(cur_chan);
    chk("R8 level", fifo_level, DEPTH);
    chk("R8 ovf", fifo_ovf, 1);
    while (smp_valid) begin
      pop(d);
      chk("R8 order", d[11:0], 12'(s0 + n));
      n++;
    end
    chk("R8 kept", n, DEPTH);
    chk("R8 sticky", fifo_ovf, 1);
    pulse_clr();
    chk("R8 clr", fifo_ovf, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_settle_hold();
    t_scan_order();
    t_req_inflight();
    t_irq();
    t_overflow();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule